// File: doc/BRIEF.md
# Strap Pin Detection and Decode Sequencer

After reset, this block reads two resistor-strapped configuration pins through an external ADC. One pin sets the bus slave address. The other sets the boot output voltage of channel A. Each enabled pin is measured twice. The first measurement is taken with the pin's high-side resistor shorted and returns the low-side resistance. The second returns the divider voltage. Each measurement code is quantized against its own sorted threshold table. The resistance bin gives the three low bits of an 8-bit decode, and the voltage bin gives the five high bits.

Once every measurement has finished, the block writes the results in a single cycle. It loads a 7-bit slave address, a channel-A voltage code in millivolts, and a channel-B voltage code. A two-bit detection-enable word, taken from the non-volatile image, decides for each pin whether its decoded value or its stored value is loaded. Channel B always takes its stored voltage. Two flags report a strap that decodes to the reserved address and a boot strap that decodes to the forbidden code. If the ADC stops answering, a timeout ends detection and every register falls back to its stored value.

Top module: `strap_detect`

## Requirements
- R1: Each enabled pin gets exactly two ADC requests. The first has `adc_short_hs_o`=1 and the second has it at 0. The address pin (`adc_pin_o`=0) is measured before the boot pin (`adc_pin_o`=1). No request is raised once `done_o` is high.
- R2: A measurement bin is the count of table thresholds that the code strictly exceeds, limited to N-1. The resistance table has 8 entries and the voltage table has 32. Threshold i sits at bits [i*ADC_W +: ADC_W].
- R3: The decode is {voltage bin[4:0], resistance bin[2:0]}. It is reported on `addr_decode_o` and `boot_decode_o`.
- R4: A detected slave address equals 88 plus decode[7:3], which covers 88 to 119.
- R5: `addr_reserved_o` is set when a detected address decode has decode[7:3] = 9, which is address 97.
- R6: A detected boot decode d from 1 to 254 gives a channel-A voltage of 240 + 10*d mV. Decode 255 gives 3300 mV.
- R7: A detected boot decode of 0 sets `boot_invalid_o`, and channel A takes its stored voltage.
- R8: `slave_addr_o`, `vout_a_o` and `vout_b_o` stay 0 until detection completes. They are all loaded in the cycle in which `done_o` rises, and `done_o` then stays high until reset.
- R9: When `strap_ovr_i[1]` is 0, the address pin is not measured and `slave_addr_o` takes `nvm_addr_i`.
- R10: When `strap_ovr_i[0]` is 0, the boot pin is not measured and `vout_a_o` takes `nvm_vout_a_i`.
- R11: `vout_b_o` always takes `nvm_vout_b_i`.
- R12: If a request goes unanswered for TIMEOUT_CYC cycles, `adc_timeout_o` is set, detection ends, and all three registers take their stored values with both flags clear.
- R13: During reset, `adc_req_o`, `done_o` and all loaded outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_ovr_i | input | 2 | Detection enables: bit 1 for the address pin, bit 0 for the boot pin |
| nvm_addr_i | input | 7 | Stored slave address |
| nvm_vout_a_i | input | 12 | Stored channel-A voltage (mV) |
| nvm_vout_b_i | input | 12 | Stored channel-B voltage (mV) |
| res_thr_i | input | 80 | Resistance threshold table, 8 entries |
| volt_thr_i | input | 320 | Voltage threshold table, 32 entries |
| adc_req_o | output | 1 | Measurement request, held until answered |
| adc_pin_o | output | 1 | Pin to measure: 0 for address, 1 for boot |
| adc_short_hs_o | output | 1 | Short the high-side resistor for this measurement |
| adc_valid_i | input | 1 | ADC result strobe |
| adc_code_i | input | 10 | ADC result |
| done_o | output | 1 | Detection complete |
| slave_addr_o | output | 7 | Loaded slave address |
| vout_a_o | output | 12 | Loaded channel-A voltage (mV) |
| vout_b_o | output | 12 | Loaded channel-B voltage (mV) |
| addr_decode_o | output | 8 | Address pin decode |
| boot_decode_o | output | 8 | Boot pin decode |
| addr_reserved_o | output | 1 | Address strap decodes to the reserved address |
| boot_invalid_o | output | 1 | Boot strap decodes to the forbidden code 0 |
| adc_timeout_o | output | 1 | ADC did not answer in time |

## Verification
The bench keeps the default 8-entry and 32-entry tables and a 10-bit ADC. This lets it place evenly spaced thresholds and sweep all 256 boot decodes and all 32 address groups in one loop. A full-scale code pushes both tables into saturation. TIMEOUT_CYC is reduced to 16, so the unanswered-request path finishes in a few cycles. The bench also runs each of the four settings of the detection-enable word.

// File: rtl/strap_pkg.sv
package strap_pkg;
  typedef enum logic [1:0] {ST_INIT, ST_MEAS, ST_LOAD, ST_DONE} strap_st_e;

  localparam int ADDR_BASE    = 88;
  localparam int ADDR_RSVD    = 9;
  localparam int VOUT_BASE_MV = 240;
  localparam int VOUT_STEP_MV = 10;
  localparam int VOUT_TOP_MV  = 3300;
endpackage

// File: rtl/strap_quant.sv
module strap_quant #(
  parameter int N   = 8,
  parameter int W   = 10,
  localparam int BW = $clog2(N),
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N*W-1:0] thr_i,
  input  logic [W-1:0]   code_i,
  output logic [BW-1:0]  bin_o
);
  localparam logic [CW-1:0] TOP = CW'(N - 1);

  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) begin
      if (code_i > thr_i[i*W +: W]) cnt = cnt + CW'(1);
    end
    bin_o = (cnt > TOP) ? BW'(TOP) : BW'(cnt);
  end
endmodule

// File: rtl/strap_seq.sv
module strap_seq #(
  parameter int LSB_W       = 3,
  parameter int MSB_W       = 5,
  parameter int TIMEOUT_CYC = 1024,
  localparam int DEC_W      = LSB_W + MSB_W,
  localparam int TW         = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             addr_en_i,
  input  logic             boot_en_i,
  input  logic             adc_valid_i,
  input  logic [LSB_W-1:0] res_bin_i,
  input  logic [MSB_W-1:0] volt_bin_i,
  output logic             adc_req_o,
  output logic             adc_pin_o,
  output logic             adc_short_hs_o,
  output logic [DEC_W-1:0] addr_dec_o,
  output logic [DEC_W-1:0] boot_dec_o,
  output logic             addr_en_o,
  output logic             boot_en_o,
  output logic             load_o,
  output logic             done_o,
  output logic             timeout_o
);
  import strap_pkg::*;

  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);

  strap_st_e        st_q;
  logic [1:0]       stp_q;   // bit1: pin, bit0: 0 = low-side step, 1 = voltage step
  logic [TW-1:0]    tcnt_q;
  logic             en_a_q, en_b_q, tmo_q;
  logic [LSB_W-1:0] a_lsb_q, b_lsb_q;
  logic [MSB_W-1:0] a_msb_q, b_msb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_INIT;
      stp_q   <= '0;
      tcnt_q  <= '0;
      en_a_q  <= 1'b0;
      en_b_q  <= 1'b0;
      tmo_q   <= 1'b0;
      a_lsb_q <= '0;
      b_lsb_q <= '0;
      a_msb_q <= '0;
      b_msb_q <= '0;
    end else begin
      unique case (st_q)
        ST_INIT: begin
          en_a_q <= addr_en_i;
          en_b_q <= boot_en_i;
          tcnt_q <= '0;
          if (addr_en_i) begin
            stp_q <= 2'd0;
            st_q  <= ST_MEAS;
          end else if (boot_en_i) begin
            stp_q <= 2'd2;
            st_q  <= ST_MEAS;
          end else begin
            st_q  <= ST_LOAD;
          end
        end
        ST_MEAS: begin
          if (adc_valid_i) begin
            tcnt_q <= '0;
            unique case (stp_q)
              2'd0: a_lsb_q <= res_bin_i;
              2'd1: a_msb_q <= volt_bin_i;
              2'd2: b_lsb_q <= res_bin_i;
              default: b_msb_q <= volt_bin_i;
            endcase
            if (stp_q == 2'd3 || (stp_q == 2'd1 && !en_b_q)) st_q <= ST_LOAD;
            else stp_q <= stp_q + 2'd1;
          end else if (tcnt_q == T_LAST) begin
            tmo_q <= 1'b1;
            st_q  <= ST_LOAD;
          end else begin
            tcnt_q <= tcnt_q + TW'(1);
          end
        end
        ST_LOAD: st_q <= ST_DONE;
        default: st_q <= ST_DONE;
      endcase
    end
  end

  assign adc_req_o      = (st_q == ST_MEAS);
  assign adc_pin_o      = stp_q[1];
  assign adc_short_hs_o = (st_q == ST_MEAS) && !stp_q[0];
  assign addr_dec_o     = {a_msb_q, a_lsb_q};
  assign boot_dec_o     = {b_msb_q, b_lsb_q};
  assign addr_en_o      = en_a_q;
  assign boot_en_o      = en_b_q;
  assign load_o         = (st_q == ST_LOAD);
  assign done_o         = (st_q == ST_DONE);
  assign timeout_o      = tmo_q;
endmodule

// File: rtl/strap_map.sv
module strap_map #(
  parameter int LSB_W  = 3,
  parameter int MSB_W  = 5,
  parameter int VOUT_W = 12,
  localparam int DEC_W = LSB_W + MSB_W
) (
  input  logic [DEC_W-1:0]  addr_dec_i,
  input  logic [DEC_W-1:0]  boot_dec_i,
  output logic [6:0]        addr_o,
  output logic              reserved_o,
  output logic [VOUT_W-1:0] mv_o,
  output logic              invalid_o
);
  import strap_pkg::*;

  logic [MSB_W-1:0] a_grp;
  assign a_grp      = addr_dec_i[DEC_W-1:LSB_W];
  assign addr_o     = 7'(ADDR_BASE) + 7'(a_grp);
  assign reserved_o = (a_grp == MSB_W'(ADDR_RSVD));
  assign invalid_o  = (boot_dec_i == '0);

  always_comb begin
    if (&boot_dec_i) mv_o = VOUT_W'(VOUT_TOP_MV);
    else mv_o = VOUT_W'(VOUT_BASE_MV) + VOUT_W'(boot_dec_i) * VOUT_W'(VOUT_STEP_MV);
  end
endmodule

// File: rtl/strap_detect.sv
module strap_detect #(
  parameter int ADC_W       = 10,
  parameter int N_RES       = 8,
  parameter int N_VOLT      = 32,
  parameter int VOUT_W      = 12,
  parameter int TIMEOUT_CYC = 1024,
  localparam int LSB_W      = $clog2(N_RES),
  localparam int MSB_W      = $clog2(N_VOLT),
  localparam int DEC_W      = LSB_W + MSB_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              strap_ovr_i,
  input  logic [6:0]              nvm_addr_i,
  input  logic [VOUT_W-1:0]       nvm_vout_a_i,
  input  logic [VOUT_W-1:0]       nvm_vout_b_i,
  input  logic [N_RES*ADC_W-1:0]  res_thr_i,
  input  logic [N_VOLT*ADC_W-1:0] volt_thr_i,
  output logic                    adc_req_o,
  output logic                    adc_pin_o,
  output logic                    adc_short_hs_o,
  input  logic                    adc_valid_i,
  input  logic [ADC_W-1:0]        adc_code_i,
  output logic                    done_o,
  output logic [6:0]              slave_addr_o,
  output logic [VOUT_W-1:0]       vout_a_o,
  output logic [VOUT_W-1:0]       vout_b_o,
  output logic [DEC_W-1:0]        addr_decode_o,
  output logic [DEC_W-1:0]        boot_decode_o,
  output logic                    addr_reserved_o,
  output logic                    boot_invalid_o,
  output logic                    adc_timeout_o
);
  logic [LSB_W-1:0]  res_bin;
  logic [MSB_W-1:0]  volt_bin;
  logic              en_a, en_b, load, tmo;
  logic [6:0]        map_addr;
  logic              map_rsvd, map_inv;
  logic [VOUT_W-1:0] map_mv;
  logic              use_a, use_b;

  strap_quant #(.N(N_RES), .W(ADC_W)) u_res_q (
    .thr_i(res_thr_i), .code_i(adc_code_i), .bin_o(res_bin)
  );

  strap_quant #(.N(N_VOLT), .W(ADC_W)) u_volt_q (
    .thr_i(volt_thr_i), .code_i(adc_code_i), .bin_o(volt_bin)
  );

  strap_seq #(.LSB_W(LSB_W), .MSB_W(MSB_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .addr_en_i      (strap_ovr_i[1]),
    .boot_en_i      (strap_ovr_i[0]),
    .adc_valid_i    (adc_valid_i),
    .res_bin_i      (res_bin),
    .volt_bin_i     (volt_bin),
    .adc_req_o      (adc_req_o),
    .adc_pin_o      (adc_pin_o),
    .adc_short_hs_o (adc_short_hs_o),
    .addr_dec_o     (addr_decode_o),
    .boot_dec_o     (boot_decode_o),
    .addr_en_o      (en_a),
    .boot_en_o      (en_b),
    .load_o         (load),
    .done_o         (done_o),
    .timeout_o      (tmo)
  );

  strap_map #(.LSB_W(LSB_W), .MSB_W(MSB_W), .VOUT_W(VOUT_W)) u_map (
    .addr_dec_i (addr_decode_o),
    .boot_dec_i (boot_decode_o),
    .addr_o     (map_addr),
    .reserved_o (map_rsvd),
    .mv_o       (map_mv),
    .invalid_o  (map_inv)
  );

  assign use_a         = en_a && !tmo;
  assign use_b         = en_b && !tmo;
  assign adc_timeout_o = tmo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slave_addr_o    <= '0;
      vout_a_o        <= '0;
      vout_b_o        <= '0;
      addr_reserved_o <= 1'b0;
      boot_invalid_o  <= 1'b0;
    end else if (load) begin
      slave_addr_o    <= use_a ? map_addr : nvm_addr_i;
      addr_reserved_o <= use_a && map_rsvd;
      boot_invalid_o  <= use_b && map_inv;
      vout_a_o        <= (use_b && !map_inv) ? map_mv : nvm_vout_a_i;
      vout_b_o        <= nvm_vout_b_i;
    end
  end
endmodule

// File: rtl/strap_detect_chk.sv
module strap_detect_chk #(
  parameter int VOUT_W = 12,
  parameter int DEC_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              adc_req_o,
  input logic              adc_short_hs_o,
  input logic              done_o,
  input logic [6:0]        slave_addr_o,
  input logic [VOUT_W-1:0] vout_a_o,
  input logic [VOUT_W-1:0] vout_b_o,
  input logic [VOUT_W-1:0] nvm_vout_b_i,
  input logic [DEC_W-1:0]  boot_decode_o,
  input logic              addr_reserved_o,
  input logic              boot_invalid_o,
  input logic              adc_timeout_o
);
  assert_hold_until_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (slave_addr_o == '0 && vout_a_o == '0 && vout_b_o == '0));

  assert_done_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  assert_quiet_after_done_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !adc_req_o);

  assert_short_needs_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_short_hs_o |-> adc_req_o);

  assert_vout_b_stored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> vout_b_o == $past(nvm_vout_b_i));

  assert_reserved_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_reserved_o |-> slave_addr_o == 7'd97);

  assert_invalid_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_invalid_o |-> boot_decode_o == '0);

  assert_timeout_ends_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_timeout_o) |=> done_o);
endmodule

bind strap_detect strap_detect_chk #(.VOUT_W(VOUT_W), .DEC_W(DEC_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .adc_req_o       (adc_req_o),
  .adc_short_hs_o  (adc_short_hs_o),
  .done_o          (done_o),
  .slave_addr_o    (slave_addr_o),
  .vout_a_o        (vout_a_o),
  .vout_b_o        (vout_b_o),
  .nvm_vout_b_i    (nvm_vout_b_i),
  .boot_decode_o   (boot_decode_o),
  .addr_reserved_o (addr_reserved_o),
  .boot_invalid_o  (boot_invalid_o),
  .adc_timeout_o   (adc_timeout_o)
);

// File: tb/strap_detect_bench.sv
`timescale 1ns/1ps
module strap_detect_bench;
  localparam int ADC_W  = 10;
  localparam int VOUT_W = 12;
  localparam int TMO    = 16;
  localparam int NVM_ADDR = 21;
  localparam int NVM_VA   = 777;
  localparam int NVM_VB   = 1234;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [1:0]        strap_ovr_i = 2'b11;
  logic [6:0]        nvm_addr_i = 7'(NVM_ADDR);
  logic [VOUT_W-1:0] nvm_vout_a_i = VOUT_W'(NVM_VA);
  logic [VOUT_W-1:0] nvm_vout_b_i = VOUT_W'(NVM_VB);
  logic [8*ADC_W-1:0]  res_thr_i;
  logic [32*ADC_W-1:0] volt_thr_i;
  logic              adc_req_o, adc_pin_o, adc_short_hs_o;
  logic              adc_valid_i = 1'b0;
  logic [ADC_W-1:0]  adc_code_i = '0;
  logic              done_o;
  logic [6:0]        slave_addr_o;
  logic [VOUT_W-1:0] vout_a_o, vout_b_o;
  logic [7:0]        addr_decode_o, boot_decode_o;
  logic              addr_reserved_o, boot_invalid_o, adc_timeout_o;

  int n_chk = 0;
  int n_err = 0;
  int n_req;

  always #2.5 clk_i = ~clk_i;

  strap_detect #(.ADC_W(ADC_W), .VOUT_W(VOUT_W), .TIMEOUT_CYC(TMO)) u_strap_detect (
    .clk_i, .rst_ni, .strap_ovr_i, .nvm_addr_i, .nvm_vout_a_i, .nvm_vout_b_i,
    .res_thr_i, .volt_thr_i, .adc_req_o, .adc_pin_o, .adc_short_hs_o,
    .adc_valid_i, .adc_code_i, .done_o, .slave_addr_o, .vout_a_o, .vout_b_o,
    .addr_decode_o, .boot_decode_o, .addr_reserved_o, .boot_invalid_o, .adc_timeout_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One boot: bins per pin/step; answer=0 leaves the ADC silent.
  task automatic run_boot(input logic [1:0] ovr, input int al, input int am,
                          input int bl, input int bm, input bit answer, input bit sat);
    int exp_pin[4];
    int exp_sh[4];
    int nsteps, guard, bin, pin, sh;
    bit zero_ok, seq_ok;
    nsteps = 0;
    if (ovr[1]) begin
      exp_pin[0] = 0; exp_sh[0] = 1; exp_pin[1] = 0; exp_sh[1] = 0; nsteps = 2;
    end
    if (ovr[0]) begin
      exp_pin[nsteps] = 1; exp_sh[nsteps] = 1;
      exp_pin[nsteps+1] = 1; exp_sh[nsteps+1] = 0; nsteps += 2;
    end
    adc_valid_i = 1'b0;
    rst_ni = 1'b0;
    strap_ovr_i = ovr;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    n_req = 0; zero_ok = 1; seq_ok = 1; guard = 0;
    while (guard < 400) begin
      @(negedge clk_i);
      guard++;
      if (done_o) break;
      if (slave_addr_o != 0 || vout_a_o != 0 || vout_b_o != 0) zero_ok = 0;
      if (adc_valid_i) adc_valid_i = 1'b0;
      else if (adc_req_o && answer) begin
        pin = adc_pin_o; sh = adc_short_hs_o;
        if (n_req >= nsteps) seq_ok = 0;
        else if (pin != exp_pin[n_req] || sh != exp_sh[n_req]) seq_ok = 0;
        if (sh != 0) begin
          bin = pin ? bl : al;
          adc_code_i = (sat && bin == 7) ? ADC_W'(1023) : ADC_W'(64 * bin);
        end else begin
          bin = pin ? bm : am;
          adc_code_i = (sat && bin == 31) ? ADC_W'(1023) : ADC_W'(32 * bin);
        end
        adc_valid_i = 1'b1;
        n_req++;
      end
    end
    adc_valid_i = 1'b0;
    chk("R8 done reached", int'(done_o), 1);
    chk("R8 outputs zero before done", int'(zero_ok), 1);
    chk("R1 request order", int'(seq_ok), 1);
    chk("R1 request count", n_req, answer ? nsteps : 0);
    chk("R1 no request after done", int'(adc_req_o), 0);
    chk("R11 vout_b stored", int'(vout_b_o), NVM_VB);
  endtask

  function automatic int exp_mv(input int d);
    if (d == 0) return NVM_VA;
    if (d == 255) return 3300;
    return 240 + 10 * d;
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) res_thr_i[i*ADC_W +: ADC_W] = ADC_W'(64 * i + 32);
    for (int j = 0; j < 32; j++) volt_thr_i[j*ADC_W +: ADC_W] = ADC_W'(32 * j + 16);

    // R13 reset state
    repeat (2) @(negedge clk_i);
    chk("R13 req in reset", int'(adc_req_o), 0);
    chk("R13 done in reset", int'(done_o), 0);
    chk("R13 addr in reset", int'(slave_addr_o), 0);
    chk("R13 vout_a in reset", int'(vout_a_o), 0);
    chk("R13 flags in reset", int'({addr_reserved_o, boot_invalid_o, adc_timeout_o}), 0);

    // R2 R3 R4 R5 R6 R7 sweep: every boot decode, every address group
    for (int k = 0; k < 256; k++) begin
      int al, am, bl, bm;
      al = k / 32; am = k % 32; bl = k % 8; bm = k / 8;
      run_boot(2'b11, al, am, bl, bm, 1'b1, (k % 3) == 0);
      chk("R2 R3 address decode", int'(addr_decode_o), am * 8 + al);
      chk("R2 R3 boot decode", int'(boot_decode_o), k);
      chk("R4 slave address", int'(slave_addr_o), 88 + am);
      chk("R5 reserved flag", int'(addr_reserved_o), (am == 9) ? 1 : 0);
      chk("R6 R7 vout_a", int'(vout_a_o), exp_mv(k));
      chk("R7 invalid flag", int'(boot_invalid_o), (k == 0) ? 1 : 0);
      chk("R12 no timeout", int'(adc_timeout_o), 0);
    end

    // R9 address detection disabled, reserved strap not seen
    run_boot(2'b01, 1, 9, 4, 10, 1'b1, 1'b0);
    chk("R9 stored address", int'(slave_addr_o), NVM_ADDR);
    chk("R9 reserved clear", int'(addr_reserved_o), 0);
    chk("R9 boot still mapped", int'(vout_a_o), 240 + 10 * 84);

    // R10 boot detection disabled, zero strap not seen
    run_boot(2'b10, 5, 30, 0, 0, 1'b1, 1'b0);
    chk("R10 stored vout_a", int'(vout_a_o), NVM_VA);
    chk("R10 invalid clear", int'(boot_invalid_o), 0);
    chk("R10 address still mapped", int'(slave_addr_o), 118);

    // R9 R10 both disabled
    run_boot(2'b00, 3, 3, 3, 3, 1'b1, 1'b0);
    chk("R9 both off address", int'(slave_addr_o), NVM_ADDR);
    chk("R10 both off vout_a", int'(vout_a_o), NVM_VA);

    // R12 silent ADC
    run_boot(2'b11, 2, 9, 0, 0, 1'b0, 1'b0);
    chk("R12 timeout flag", int'(adc_timeout_o), 1);
    chk("R12 stored address", int'(slave_addr_o), NVM_ADDR);
    chk("R12 stored vout_a", int'(vout_a_o), NVM_VA);
    chk("R12 flags clear", int'({addr_reserved_o, boot_invalid_o}), 0);

    // R8 done stays high
    repeat (5) @(negedge clk_i);
    chk("R8 done sticky", int'(done_o), 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule